// File: doc/BRIEF.md
# Microcode Branch and Call Sequencer

This block is the program-counter unit of a small command-processor microcontroller. Each cycle it drives a fetch address. The instruction word at that address comes back in the same cycle, together with the value of the register that the word names as its source. From these the block works out the next fetch address. Non-control instructions step to the following word. The control-flow group covers four things: conditional relative branches, absolute subroutine calls, returns through a hardware return stack, and a wait-for-input instruction.

Two branch flavours share one 5-bit operand field. In the first, the field is an immediate that is compared with the whole source register. In the second, it is a bit index that picks one bit of the register to test. The wait-for-input instruction compares the write and read pointers of the command input stream. When the two pointers are equal it parks the sequencer in a stall state, and it stays there until new data arrives. A return can also be flagged as the exit from a context-switch interrupt handler. The block then reports that exit on a one-cycle output.

Top module: `mseq_pc_unit`

## Requirements
- R1: While `rst_n` is low, `pc` is 0 and `stall`, `ovf` and `unf` are 0.
- R2: Opcode `instr[31:26]` 0x30 branches when the source value differs from the zero-extended `instr[20:16]`, and 0x31 branches when the two are equal. A taken branch loads `pc` + sign-extended `instr[15:0]` (modulo 2^PC_W). A branch that is not taken loads `pc`+1.
- R3: Opcode 0x32 branches when bit `instr[20:16]` of the source value is 0, and opcode 0x33 branches when that bit is 1. The target rules are the same as in R2.
- R4: Opcode 0x35 loads `pc` with the low PC_W bits of `instr[25:0]` and pushes `pc`+1 onto the return stack.
- R5: Opcode 0x34 loads `pc` with the most recently pushed return address and removes it from the stack, so nested calls return in last-in first-out order.
- R6: The stack holds DEPTH (default 8) entries. A call made while the stack is full still jumps, but its return address is dropped and the sticky `ovf` output is set. `ovf` stays set until reset.
- R7: A return on an empty stack loads `pc`+1 and sets the sticky `unf` output, which stays set until reset.
- R8: `irq_ret` is high in exactly those cycles in which an issued return has `instr[25]` = 1.
- R9: Opcode 0x36 issued with `wr_ptr` != `rd_ptr` loads `pc`+1 with no stall. Issued with the pointers equal, it holds `pc` and raises `stall`. While `stall` is high, `issue` is 0 and `instr_vld` is ignored.
- R10: In a stall cycle in which `wr_ptr` != `rd_ptr`, the next cycle has `stall` low and `pc` one higher than the held value.
- R11: `issue` equals `instr_vld` && !`stall`. With `instr_vld` low outside a stall, `pc` holds. Any other opcode, including 0x37 to 0x3f and everything below 0x30, loads `pc`+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_vld | input | 1 | Instruction word at `pc` is present this cycle |
| instr | input | 32 | Fetched instruction word |
| rs_val | input | 32 | Value of the register named by `instr[25:21]` |
| wr_ptr | input | PTR_W | Command stream write pointer |
| rd_ptr | input | PTR_W | Command stream read pointer |
| pc | output | PC_W | Fetch address |
| issue | output | 1 | Instruction at `pc` is consumed this cycle |
| stall | output | 1 | Waiting for input |
| irq_ret | output | 1 | Return from interrupt handler issued |
| ovf | output | 1 | Sticky return stack overflow |
| unf | output | 1 | Sticky return stack underflow |

## Verification
The branch opcodes are tried in three kinds of case. Source values equal to the immediate and differing from it show whether the compare sense is right. A value that matches in its low five bits but not above them shows that the immediate is zero-extended and not truncated against the register. For the bit-test flavour, bits 0, 17 and 31 are set or cleared to prove that the index selects the right bit. Forward and backward offsets separate sign extension from plain addition. Calls are nested three deep and then nine deep, so that last-in first-out order, the dropped push at the full boundary, and the underflow on the final return are each seen. Wait-for-input is issued both with data already pending and with equal pointers, and valid instruction words are offered during the stall so that any leak past the stall would show up.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  localparam int INSTR_W = 32;
  localparam int OP_W    = 6;

  typedef enum logic [OP_W-1:0] {
    OP_BNE_IMM = 6'h30,
    OP_BEQ_IMM = 6'h31,
    OP_BNE_BIT = 6'h32,
    OP_BEQ_BIT = 6'h33,
    OP_RETURN  = 6'h34,
    OP_CALL    = 6'h35,
    OP_WAIT_IN = 6'h36
  } ctl_op_e;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_WAIT = 1'b1
  } wait_st_e;

  typedef struct packed {
    logic        is_br;
    logic        br_taken;
    logic        is_call;
    logic        is_ret;
    logic        ret_irq;
    logic        is_wait;
    logic [15:0] off;
    logic [25:0] target;
  } dec_t;

endpackage

// File: rtl/mseq_decode.sv
module mseq_decode
  import mseq_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  input  logic [31:0]        rs_val,
  output dec_t               dec
);

  logic [OP_W-1:0] op;
  logic [4:0]      field5;
  logic            imm_eq;
  logic            bit_sel;

  assign op      = instr[31:26];
  assign field5  = instr[20:16];
  assign imm_eq  = (rs_val == {27'd0, field5});
  assign bit_sel = rs_val[field5];

  always_comb begin
    dec          = '0;
    dec.off      = instr[15:0];
    dec.target   = instr[25:0];
    dec.ret_irq  = instr[25];
    case (op)
      OP_BNE_IMM: begin dec.is_br = 1'b1; dec.br_taken = ~imm_eq;  end
      OP_BEQ_IMM: begin dec.is_br = 1'b1; dec.br_taken =  imm_eq;  end
      OP_BNE_BIT: begin dec.is_br = 1'b1; dec.br_taken = ~bit_sel; end
      OP_BEQ_BIT: begin dec.is_br = 1'b1; dec.br_taken =  bit_sel; end
      OP_RETURN:  dec.is_ret  = 1'b1;
      OP_CALL:    dec.is_call = 1'b1;
      OP_WAIT_IN: dec.is_wait = 1'b1;
      default:    ;
    endcase
  end

endmodule

// File: rtl/mseq_ret_stack.sv
module mseq_ret_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         ovf,
  output logic         unf
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_m1;
  logic             full;
  logic             cnt_en;
  logic             ovf_d, unf_d;
  logic [IDX_W-1:0] top_idx;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign cnt_m1  = cnt_q - CNT_W'(1);
  assign top_idx = cnt_m1[IDX_W-1:0];
  assign top     = mem[top_idx];

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    ovf_d  = ovf;
    unf_d  = unf;
    if (push) begin
      if (full) begin
        ovf_d = 1'b1;
      end else begin
        cnt_d  = cnt_q + CNT_W'(1);
        cnt_en = 1'b1;
      end
    end else if (pop) begin
      if (empty) begin
        unf_d = 1'b1;
      end else begin
        cnt_d  = cnt_m1;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf   <= 1'b0;
      unf   <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      ovf <= ovf_d;
      unf <= unf_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic wr_en;
    assign wr_en = push && !full && (cnt_q == CNT_W'(i));
    always_ff @(posedge clk) begin
      if (wr_en) mem[i] <= push_data;
    end
  end

endmodule

// File: rtl/mseq_wait_ctl.sv
module mseq_wait_ctl
  import mseq_pkg::*;
#(
  parameter int PTR_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_issue,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic             stall,
  output logic             ready
);

  wait_st_e st_q, st_d;

  assign ready = (wr_ptr != rd_ptr);
  assign stall = (st_q == ST_WAIT);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_RUN:  if (win_issue && !ready) st_d = ST_WAIT;
      ST_WAIT: if (ready)               st_d = ST_RUN;
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/mseq_pc_unit.sv
module mseq_pc_unit
  import mseq_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int PTR_W   = 12,
  parameter int RS_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_vld,
  input  logic [31:0]      instr,
  input  logic [31:0]      rs_val,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic [PC_W-1:0]  pc,
  output logic             issue,
  output logic             stall,
  output logic             irq_ret,
  output logic             ovf,
  output logic             unf
);

  // PC_W must stay within 16..26 so both the offset and the call target fit
  localparam int OFF_PAD = PC_W - 16;

  dec_t            dec;
  logic [PC_W-1:0] pc_d, pc_inc, pc_rel, rs_top;
  logic            pc_en;
  logic            push, pop, win_issue, rs_empty, ready;

  mseq_decode u_dec (
    .instr  (instr),
    .rs_val (rs_val),
    .dec    (dec)
  );

  mseq_ret_stack #(.DEPTH(RS_DEPTH), .W(PC_W)) u_stk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .pop       (pop),
    .push_data (pc_inc),
    .top       (rs_top),
    .empty     (rs_empty),
    .ovf       (ovf),
    .unf       (unf)
  );

  mseq_wait_ctl #(.PTR_W(PTR_W)) u_wait (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_issue (win_issue),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .stall     (stall),
    .ready     (ready)
  );

  assign issue     = instr_vld && !stall;
  assign push      = issue && dec.is_call;
  assign pop       = issue && dec.is_ret;
  assign win_issue = issue && dec.is_wait;
  assign irq_ret   = pop && dec.ret_irq;

  assign pc_inc = pc + PC_W'(1);
  assign pc_rel = pc + {{OFF_PAD{dec.off[15]}}, dec.off};

  always_comb begin
    pc_d = pc_inc;
    if (issue) begin
      if (dec.is_br && dec.br_taken) pc_d = pc_rel;
      else if (dec.is_call)          pc_d = dec.target[PC_W-1:0];
      else if (dec.is_ret && !rs_empty) pc_d = rs_top;
      else if (dec.is_wait && !ready)   pc_d = pc;
    end
  end

  assign pc_en = stall ? ready : instr_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc <= '0;
    else if (pc_en) pc <= pc_d;
  end

endmodule

// File: rtl/mseq_pc_unit_chk.sv
module mseq_pc_unit_chk #(
  parameter int PC_W  = 16,
  parameter int PTR_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             instr_vld,
  input logic [31:0]      instr,
  input logic [PTR_W-1:0] wr_ptr,
  input logic [PTR_W-1:0] rd_ptr,
  input logic [PC_W-1:0]  pc,
  input logic             issue,
  input logic             stall,
  input logic             irq_ret,
  input logic             ovf,
  input logic             unf
);

  p_stall_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!issue && !irq_ret));

  p_wait_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && wr_ptr == rd_ptr) |=> (stall && pc == $past(pc)));

  p_win_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && instr[31:26] == 6'h36 && wr_ptr != rd_ptr)
      |=> (!stall && pc == $past(pc) + PC_W'(1)));

  p_wake_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && wr_ptr != rd_ptr) |=> (!stall && pc == $past(pc) + PC_W'(1)));

  p_call_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && instr[31:26] == 6'h35) |=> (pc == $past(instr[PC_W-1:0])));

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  p_unf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    unf |=> unf);

  p_irq_only_ret_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ret |-> (issue && instr[31:26] == 6'h34 && instr[25]));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !instr_vld) |=> (!stall && pc == $past(pc)));

endmodule

bind mseq_pc_unit mseq_pc_unit_chk #(.PC_W(PC_W), .PTR_W(PTR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .instr_vld (instr_vld),
  .instr     (instr),
  .wr_ptr    (wr_ptr),
  .rd_ptr    (rd_ptr),
  .pc        (pc),
  .issue     (issue),
  .stall     (stall),
  .irq_ret   (irq_ret),
  .ovf       (ovf),
  .unf       (unf)
);

// File: tb/tb_mseq_pc_unit.sv
module tb_mseq_pc_unit;

  localparam int PC_W  = 16;
  localparam int PTR_W = 12;
  localparam int DEPTH = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             instr_vld;
  logic [31:0]      instr, rs_val;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [PC_W-1:0]  pc;
  logic             issue, stall, irq_ret, ovf, unf;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [PC_W-1:0] m_pc;
  bit              m_stall, m_ovf, m_unf;
  logic [PC_W-1:0] m_stack[$];

  always #4 clk = ~clk;

  mseq_pc_unit #(.PC_W(PC_W), .PTR_W(PTR_W), .RS_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .instr_vld(instr_vld), .instr(instr),
    .rs_val(rs_val), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .pc(pc),
    .issue(issue), .stall(stall), .irq_ret(irq_ret), .ovf(ovf), .unf(unf)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] br(input logic [5:0] op, input logic [4:0] f5,
                                     input logic [15:0] off);
    return {op, 5'd3, f5, off};
  endfunction

  function automatic logic [31:0] call_w(input logic [25:0] a);
    return {6'h35, a};
  endfunction

  function automatic logic [31:0] ret_w(input bit irq);
    return {6'h34, irq, 25'd0};
  endfunction

  localparam logic [31:0] WIN_W = {6'h36, 26'd0};

  task automatic step(input logic [31:0] ins, input bit v, input logic [31:0] rs,
                      input logic [PTR_W-1:0] wp, input logic [PTR_W-1:0] rp,
                      input string tag);
    logic [5:0] op;
    bit         e_issue, e_irq, take;
    int         off;
    @(negedge clk);
    instr = ins; instr_vld = v; rs_val = rs; wr_ptr = wp; rd_ptr = rp;
    #1;
    op      = ins[31:26];
    e_issue = v && !m_stall;
    e_irq   = e_issue && op == 6'h34 && ins[25];
    chk(tag, "pc",      32'(pc),      32'(m_pc));
    chk(tag, "stall",   32'(stall),   32'(m_stall));
    chk(tag, "issue",   32'(issue),   32'(e_issue));
    chk(tag, "irq_ret", 32'(irq_ret), 32'(e_irq));
    chk(tag, "ovf",     32'(ovf),     32'(m_ovf));
    chk(tag, "unf",     32'(unf),     32'(m_unf));
    if (m_stall) begin
      if (wp != rp) begin m_stall = 0; m_pc = m_pc + 16'd1; end
    end else if (v) begin
      off  = int'($signed(ins[15:0]));
      take = 0;
      case (op)
        6'h30: take = (rs != {27'd0, ins[20:16]});
        6'h31: take = (rs == {27'd0, ins[20:16]});
        6'h32: take = !rs[ins[20:16]];
        6'h33: take =  rs[ins[20:16]];
        default: ;
      endcase
      if (op >= 6'h30 && op <= 6'h33) begin
        m_pc = take ? PC_W'(int'(m_pc) + off) : m_pc + 16'd1;
      end else if (op == 6'h35) begin
        if (m_stack.size() < DEPTH) m_stack.push_back(m_pc + 16'd1);
        else m_ovf = 1;
        m_pc = ins[PC_W-1:0];
      end else if (op == 6'h34) begin
        if (m_stack.size() > 0) m_pc = m_stack.pop_back();
        else begin m_unf = 1; m_pc = m_pc + 16'd1; end
      end else if (op == 6'h36) begin
        if (wp != rp) m_pc = m_pc + 16'd1;
        else m_stall = 1;
      end else begin
        m_pc = m_pc + 16'd1;
      end
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; instr_vld = 0; instr = '0; rs_val = '0; wr_ptr = '0; rd_ptr = '0;
    m_pc = '0; m_stall = 0; m_ovf = 0; m_unf = 0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1", "pc",    32'(pc),    0);
    chk("R1", "stall", 32'(stall), 0);
    chk("R1", "ovf",   32'(ovf),   0);
    chk("R1", "unf",   32'(unf),   0);
    @(negedge clk); rst_n = 1;

    // R11 idle hold and plain opcodes
    step('0, 0, 0, 0, 0, "R11");
    step('0, 0, 0, 0, 0, "R11");
    step(32'h0400_0000, 1, 0, 0, 0, "R11");
    step({6'h37, 26'h3ff_ffff}, 1, 0, 0, 0, "R11");
    step({6'h2f, 26'h155_5555}, 1, 0, 0, 0, "R11");

    // R2 immediate compare branches
    step(br(6'h30, 5'd5, 16'd10), 1, 32'd5, 0, 0, "R2");
    step(br(6'h30, 5'd5, 16'd10), 1, 32'd6, 0, 0, "R2");
    step(br(6'h31, 5'd7, 16'hfffd), 1, 32'd7, 0, 0, "R2");
    step(br(6'h31, 5'd7, 16'd20), 1, 32'h27, 0, 0, "R2");
    step(br(6'h30, 5'd7, 16'd4), 1, 32'h1_0007, 0, 0, "R2");
    step(br(6'h31, 5'd0, 16'h8000), 1, 32'd0, 0, 0, "R2");

    // R3 bit test branches
    step(br(6'h32, 5'd31, 16'd9), 1, 32'h8000_0000, 0, 0, "R3");
    step(br(6'h32, 5'd31, 16'd9), 1, 32'h7fff_ffff, 0, 0, "R3");
    step(br(6'h33, 5'd0, 16'hfff0), 1, 32'h1, 0, 0, "R3");
    step(br(6'h33, 5'd17, 16'd3), 1, 32'hfffd_ffff, 0, 0, "R3");
    step(br(6'h33, 5'd17, 16'd3), 1, 32'h0002_0000, 0, 0, "R3");

    // R4 R5 nested calls and returns
    step(call_w(26'h100), 1, 0, 0, 0, "R4");
    step('0, 1, 0, 0, 0, "R4");
    step(call_w(26'h3_2200), 1, 0, 0, 0, "R4");
    step(call_w(26'h300), 1, 0, 0, 0, "R4");
    step(ret_w(0), 1, 0, 0, 0, "R5");
    step(ret_w(0), 1, 0, 0, 0, "R5");
    step(ret_w(1), 1, 0, 0, 0, "R8");
    step('0, 1, 0, 0, 0, "R8");

    // R9 R10 wait for input
    step(WIN_W, 1, 0, 12'd5, 12'd4, "R9");
    step(WIN_W, 1, 0, 12'd4, 12'd4, "R9");
    step(call_w(26'h50), 1, 0, 12'd4, 12'd4, "R9");
    step(ret_w(1), 1, 0, 12'd4, 12'd4, "R9");
    step(ret_w(1), 1, 0, 12'd5, 12'd4, "R10");
    step('0, 1, 0, 12'd5, 12'd4, "R10");

    // R6 R7 overflow and underflow
    for (int i = 0; i < DEPTH + 1; i++)
      step(call_w(26'(16'h1000 + 16'(i * 16))), 1, 0, 0, 0, "R6");
    step('0, 1, 0, 0, 0, "R6");
    for (int i = 0; i < DEPTH + 1; i++)
      step(ret_w(0), 1, 0, 0, 0, "R7");
    step(ret_w(1), 1, 0, 0, 0, "R7");
    step('0, 0, 0, 0, 0, "R7");
    step(call_w(26'h20), 1, 0, 0, 0, "R6");
    step(ret_w(0), 1, 0, 0, 0, "R7");
    step('0, 0, 0, 0, 0, "R7");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule